// File: doc/BRIEF.md
# Burst-of-Two Separate-Port Synchronous SRAM

This block is a cycle-level, synthesizable model of a synchronous static RAM with an independent read port and write port. Every accepted request moves exactly two data words, held at two neighbouring internal locations. The external address selects a pair of words. The block supplies the lowest bit of the word address itself, so the external address is one bit narrower than the internal word address. The double-data-rate transfer of a real device becomes two beats on consecutive cycles of a single clock.

A read and a write may be requested in the same cycle and share one address bus. Read data leaves through an output register together with a valid strobe, two cycles after the request. Write data and its active-low byte mask arrive in two beats: the first beat in the request cycle and the second in the following cycle. Each beat carries its own mask. The read and write paths are coherent. A read returns every byte written by any write accepted in or before its own cycle, and no byte written by a later write.

Neither edge applies back-pressure. The consumer of read data must take each beat in the cycle that `rd_valid` is high, because there is no ready input. A port is busy for the one cycle after it accepts a request, and it ignores a request in that cycle.

Top module: `sram_b2_sep`

## Requirements
- R1: While `rst_n` is low, and until the first read is accepted after reset, `rd_valid` is 0, `rd_data` is 0, and every word reads as 0.
- R2: A read is accepted when `rd_req_n` is 0 in a cycle where the read port did not accept a read in the previous cycle. A read request in the cycle right after an accepted read is ignored and produces no data beats.
- R3: A read accepted in cycle t drives `rd_valid` high in cycles t+2 and t+3 only. `rd_data` carries word {addr,0} in t+2 and word {addr,1} in t+3, and is 0 whenever `rd_valid` is low.
- R4: The internal word address is {external address, beat bit}. The beat bit is 0 for the first beat and 1 for the second, and it never comes from the pins. The array therefore holds 2^(ADDR_W+1) distinct words.
- R5: A write accepted in cycle t stores `wr_data` from cycle t into word {addr,0} and `wr_data` from cycle t+1 into word {addr,1}.
- R6: `wr_be_n` is active low and is sampled with each beat. Bit i guards lane i, which is `wr_data[9i+8:9i]`. A lane whose bit is 1 keeps its old contents.
- R7: A write is accepted when `wr_req_n` is 0 in a cycle where the write port did not accept a write in the previous cycle. A write request in the cycle right after an accepted write is ignored and changes no word.
- R8: When a read and a write to the same address are accepted in the same cycle, both returned beats hold the newly written data, merged lane by lane with the old contents.
- R9: A read returns the effect of every write accepted in or before its acceptance cycle, including a write accepted one cycle earlier whose second beat is still arriving. It returns no effect of a write accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_n | input | 1 | Active-low read request |
| wr_req_n | input | 1 | Active-low write request |
| addr | input | ADDR_W | Shared word-pair address |
| wr_data | input | DATA_W | Write data beat |
| wr_be_n | input | DATA_W/LANE_W | Active-low per-lane write mask for the current beat |
| rd_data | output | DATA_W | Registered read data beat |
| rd_valid | output | 1 | High for each read data beat |

## Verification
The bench builds the block with its defaults: a 5-bit external address, which gives 64 words, and 18-bit data split into two 9-bit lanes. A small address space makes random reads and writes hit the same pair often, so same-cycle collisions, reads that follow a write by one cycle, and reads that precede one are all common. It also allows every one of the 64 words to be written and read back, which checks that the beat bit separates the two words of each pair. Two lanes keep all four mask patterns within reach on both beats.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;
  // Position of a port inside its two-beat burst
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } burst_ph_e;
endpackage

// File: rtl/sram_b2_wr_port.sv
module sram_b2_wr_port
  import sram_b2_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2,
  localparam int WORD_AW = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [LANES-1:0]   be_n,
  output logic               acc,
  output logic               we,
  output logic [WORD_AW-1:0] waddr,
  output logic [LANES-1:0]   wmask
);
  burst_ph_e         ph_q;
  logic [ADDR_W-1:0] addr_q;
  logic              busy;

  assign busy = (ph_q == PH_SECOND);
  assign acc  = rst_n & ~req_n & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      addr_q <= '0;
    end else if (acc) begin
      ph_q   <= PH_SECOND;
      addr_q <= addr;
    end else begin
      ph_q   <= PH_IDLE;
    end
  end

  // First beat commits in the request cycle, second beat one cycle later
  assign we    = acc | busy;
  assign waddr = busy ? {addr_q, 1'b1} : {addr, 1'b0};
  assign wmask = ~be_n & {LANES{we}};
endmodule

// File: rtl/sram_b2_rd_port.sv
module sram_b2_rd_port
  import sram_b2_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 18,
  localparam int WORD_AW = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  arr_q,
  output logic               acc,
  output logic [WORD_AW-1:0] raddr,
  output logic               rvalid,
  output logic [DATA_W-1:0]  rdata
);
  burst_ph_e         ph_q;
  logic [ADDR_W-1:0] addr_q;
  logic              busy;
  logic              fetching;

  assign busy     = (ph_q == PH_FIRST);
  assign acc      = rst_n & ~req_n & ~busy;
  assign fetching = (ph_q != PH_IDLE);
  assign raddr    = {addr_q, (ph_q == PH_SECOND)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      addr_q <= '0;
    end else if (acc) begin
      ph_q   <= PH_FIRST;
      addr_q <= addr;
    end else if (ph_q == PH_FIRST) begin
      ph_q   <= PH_SECOND;
    end else begin
      ph_q   <= PH_IDLE;
    end
  end

  // Output register stage: array is read one cycle after acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= fetching;
      rdata  <= fetching ? arr_q : '0;
    end
  end
endmodule

// File: rtl/sram_b2_store.sv
module sram_b2_store #(
  parameter int WORD_AW = 6,
  parameter int LANE_W  = 9,
  parameter int LANES   = 2,
  localparam int DEPTH  = 1 << WORD_AW,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [WORD_AW-1:0] waddr,
  input  logic [LANES-1:0]   wmask,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [WORD_AW-1:0] raddr,
  output logic [DATA_W-1:0]  rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (we && wmask[g]) begin
        cells[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
  end
endmodule

// File: rtl/sram_b2_sep.sv
module sram_b2_sep #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 18,
  parameter int LANE_W = 9,
  localparam int LANES   = DATA_W / LANE_W,
  localparam int WORD_AW = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_n,
  input  logic              wr_req_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_be_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic               rd_acc;
  logic               wr_acc;
  logic               wr_we;
  logic [WORD_AW-1:0] wr_waddr;
  logic [LANES-1:0]   wr_mask;
  logic [WORD_AW-1:0] rd_raddr;
  logic [DATA_W-1:0]  arr_rd;

  sram_b2_wr_port #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_n), .req_n(wr_req_n), .addr(addr), .be_n(wr_be_n),
    .acc(wr_acc), .we(wr_we), .waddr(wr_waddr), .wmask(wr_mask)
  );

  sram_b2_store #(.WORD_AW(WORD_AW), .LANE_W(LANE_W), .LANES(LANES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_we), .waddr(wr_waddr), .wmask(wr_mask),
    .wdata(wr_data), .raddr(rd_raddr), .rdata(arr_rd)
  );

  sram_b2_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .req_n(rd_req_n), .addr(addr), .arr_q(arr_rd),
    .acc(rd_acc), .raddr(rd_raddr), .rvalid(rd_valid), .rdata(rd_data)
  );
endmodule

// File: rtl/sram_b2_sep_chk.sv
module sram_b2_sep_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_acc,
  input logic              wr_acc,
  input logic              wr_we,
  input logic              wr_lsb,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);
  AST_RD_TWO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> ##1 rd_valid ##1 rd_valid); // R3
  AST_RVALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_acc, 2) || $past(rd_acc, 3))); // R3
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0)); // R3
  AST_RD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> !rd_acc); // R2
  AST_WR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !wr_acc); // R7
  AST_WR_FIRST_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |-> (wr_we && !wr_lsb)); // R4
  AST_WR_SECOND_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_acc) |-> (wr_we && wr_lsb)); // R4
endmodule

bind sram_b2_sep sram_b2_sep_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc), .wr_acc(wr_acc), .wr_we(wr_we),
  .wr_lsb(wr_waddr[0]), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/test_sram_b2_sep.sv
module test_sram_b2_sep;
  localparam int AW = 5;
  localparam int DW = 18;
  localparam int LW = 9;
  localparam int NL = DW / LW;
  localparam int NWORDS = 1 << (AW + 1);
  localparam int WATCHDOG_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_req_n = 1'b1;
  logic          wr_req_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NL-1:0] wr_be_n = '1;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  always #5 clk = ~clk;

  sram_b2_sep #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW)) i_sram_b2_sep (
    .clk(clk), .rst_n(rst_n), .rd_req_n(rd_req_n), .wr_req_n(wr_req_n),
    .addr(addr), .wr_data(wr_data), .wr_be_n(wr_be_n),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  // Behavioural reference state
  logic [DW-1:0] ref_mem [NWORDS];
  bit            rd_prev_acc = 0, wr_prev_acc = 0;
  int            rd_prev_addr = 0, wr_prev_addr = 0;
  bit            exp_now_v = 0, exp_next_v = 0;
  logic [DW-1:0] exp_now_d = '0, exp_next_d = '0;

  task automatic check(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic merge(input int w, input logic [DW-1:0] d, input logic [NL-1:0] m_n);
    for (int l = 0; l < NL; l++)
      if (!m_n[l]) ref_mem[w][l*LW +: LW] = d[l*LW +: LW];
  endtask

  // Applied right after each rising edge, from the inputs sampled there
  task automatic ref_edge();
    bit racc, wacc;
    racc = !rd_req_n && !rd_prev_acc;
    wacc = !wr_req_n && !wr_prev_acc;
    if (wr_prev_acc) merge(wr_prev_addr * 2 + 1, wr_data, wr_be_n); // R5 second beat
    if (wacc) merge(int'(addr) * 2, wr_data, wr_be_n);              // R5 first beat
    exp_now_v = exp_next_v;
    exp_now_d = exp_next_d;
    if (racc) begin
      exp_next_v = 1; exp_next_d = ref_mem[int'(addr) * 2];
    end else if (rd_prev_acc) begin
      exp_next_v = 1; exp_next_d = ref_mem[rd_prev_addr * 2 + 1];
    end else begin
      exp_next_v = 0; exp_next_d = '0;
    end
    if (racc) rd_prev_addr = int'(addr);
    if (wacc) wr_prev_addr = int'(addr);
    rd_prev_acc = racc;
    wr_prev_acc = wacc;
  endtask

  task automatic compare();
    check(rd_valid == exp_now_v, "rd_valid", DW'(rd_valid), DW'(exp_now_v));
    check(rd_data == exp_now_d, "rd_data", rd_data, exp_now_d);
  endtask

  // Drive at the falling edge, clock once, then compare at the next falling edge
  task automatic step(input bit r_n, input bit w_n, input int a, input logic [DW-1:0] d, input logic [NL-1:0] m_n);
    rd_req_n = r_n; wr_req_n = w_n; addr = AW'(a); wr_data = d; wr_be_n = m_n;
    @(posedge clk);
    ref_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 0, '0, '1);
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    tag = "R1";
    check(rd_valid == 1'b0, "rd_valid in reset", DW'(rd_valid), '0);
    check(rd_data == '0, "rd_data in reset", rd_data, '0);
    rst_n = 1'b1;
    idle(2);
    step(0, 1, 17, '0, '1); idle(3);   // R1: fresh array reads zero

    tag = "R5";
    step(1, 0, 3, 18'h1_2345, 2'b00);
    step(1, 1, 0, 18'h2_abcd, 2'b00);
    step(0, 1, 3, '0, '1); idle(3);

    tag = "R6";
    step(1, 0, 3, 18'h3_ffff, 2'b01);  // only upper lane on first beat
    step(1, 1, 0, 18'h0_0000, 2'b10);  // only lower lane on second beat
    step(0, 1, 3, '0, '1); idle(3);
    step(1, 0, 3, 18'h1_1111, 2'b11);  // fully masked
    step(1, 1, 0, 18'h2_2222, 2'b11);
    step(0, 1, 3, '0, '1); idle(3);

    tag = "R2";
    step(0, 1, 3, '0, '1);
    step(0, 1, 4, '0, '1);             // ignored
    idle(4);

    tag = "R7";
    step(1, 0, 5, 18'h0_5a5a, 2'b00);
    step(1, 0, 6, 18'h0_a5a5, 2'b00);  // ignored, data is beat two of 5
    step(0, 1, 6, '0, '1); idle(3);
    step(0, 1, 5, '0, '1); idle(3);

    tag = "R8";
    step(0, 0, 7, 18'h3_0f0f, 2'b00);
    step(1, 1, 0, 18'h1_f0f0, 2'b10);
    idle(4);

    tag = "R9";
    step(1, 0, 8, 18'h2_4680, 2'b00);
    step(0, 1, 8, 18'h1_3579, 2'b00);  // read while beat two arrives
    idle(4);
    step(0, 1, 9, '0, '1);
    step(1, 0, 9, 18'h3_3333, 2'b00);  // later write must not be seen
    step(1, 1, 0, 18'h3_4444, 2'b00);
    idle(3);
    step(0, 1, 9, '0, '1); idle(3);

    tag = "R4";
    for (int a = 0; a < (1 << AW); a++) begin
      step(1, 0, a, DW'(a * 2 + 18'h100), 2'b00);
      step(1, 1, 0, DW'(a * 2 + 18'h101), 2'b00);
    end
    for (int a = 0; a < (1 << AW); a++) begin
      step(0, 1, a, '0, '1);
      step(1, 1, 0, '0, '1);
    end
    idle(3);

    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 1), $urandom_range(0, 1),
           (i % 3 == 0) ? $urandom_range(0, (1 << AW) - 1) : $urandom_range(0, 3),
           DW'($urandom), NL'($urandom));
    end
    idle(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL %s watchdog: actual %0d cycles expected completion", tag, WATCHDOG_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule